// File: doc/BRIEF.md
# Single-Precision Min/Max and Compare Unit

This is a purely combinational datapath slice for a scalar floating-point pipe. It takes two single-precision operands and a two-bit operation code, and returns either one of the operands or a 0/1 compare result. The operation code chooses minimum, maximum, less-or-equal or less-than. Beside it, a five-bit exception flag vector comes out, and only its invalid bit can ever be set.

Two variant inputs adjust how NaNs are handled. `nanprop_i` makes minimum and maximum return the canonical NaN whenever any operand is a NaN. `quiet_i` stops the compares from raising invalid when the only NaNs present are quiet ones. Each variant input applies only to its own operation pair. The surrounding pipe registers the inputs and outputs. The unit adds no cycles of its own.

Top module: `fp_minmax_cmp`

## Requirements
- R1: `op_i` encodes 0 = minimum, 1 = maximum, 2 = less-or-equal, 3 = less-than. With no NaN operand, minimum returns the numerically smaller operand and maximum returns the larger, bit for bit.
- R2: Minimum and maximum order -0.0 (0x80000000) below +0.0 (0x00000000). Minimum of the pair gives -0.0 and maximum gives +0.0, in either operand order.
- R3: With `nanprop_i`=0, min/max of one NaN and one non-NaN returns the non-NaN operand. If both operands are NaN, it returns the canonical NaN 0x7FC00000.
- R4: With `nanprop_i`=1, min/max returns 0x7FC00000 if either operand is any NaN. Otherwise it behaves as in R1 and R2.
- R5: A compare drives its truth value on `result_o[0]` and zero on bits 31:1. The compare is numeric, so -0.0 and +0.0 count as equal.
- R6: A compare with a NaN in either operand returns 0.
- R7: With `quiet_i`=0, a compare that sees any NaN operand sets the invalid flag, `flags_o[4]`.
- R8: With `quiet_i`=1, a compare sets `flags_o[4]` only if an operand is a signaling NaN. A signaling NaN has an all-ones exponent, mantissa bit 22 clear, and a nonzero mantissa. Quiet NaNs (bit 22 set) leave the flag clear.
- R9: Min/max sets `flags_o[4]` exactly when an operand is a signaling NaN, for both values of `nanprop_i`.
- R10: `flags_o[3:0]` is always zero.
- R11: `nanprop_i` has no effect on compares, and `quiet_i` has no effect on min/max, on either the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, IEEE single precision |
| b_i | input | 32 | Second operand, IEEE single precision |
| op_i | input | 2 | Operation: 0 min, 1 max, 2 le, 3 lt |
| nanprop_i | input | 1 | Min/max returns canonical NaN on any NaN input |
| quiet_i | input | 1 | Compares do not flag quiet NaNs as invalid |
| result_o | output | 32 | Selected operand, canonical NaN, or 0/1 |
| flags_o | output | 5 | Exception flags; bit 4 invalid, bits 3:0 always 0 |

## Verification
The bench sweeps every ordered pair from a set of seventeen operands, under all four operations and all four variant settings. The set covers both infinities, the largest normals, smallest subnormals, both zeros, ordinary values, quiet NaNs with and without payload, and signaling NaNs of both signs. Sign-magnitude mistakes would show up as inverted results for negative pairs or a wrong ±0 order. Comparing zeros by their bits would make le(+0,-0) return 0. Passing a NaN payload through, or leaking it into min/max, would give a result other than 0x7FC00000. Swapping the roles of the two variant bits, or the quiet/signaling test, would raise invalid on a quiet NaN or miss one on a signaling NaN.

// File: rtl/fpu_mc_pkg.sv
package fpu_mc_pkg;
  parameter int unsigned EXP_W = 8;
  parameter int unsigned MAN_W = 23;
  parameter int unsigned FLEN  = 1 + EXP_W + MAN_W;
  parameter int unsigned FLAG_W = 5;
  parameter int unsigned NV_BIT = 4;

  typedef enum logic [1:0] {
    OP_MIN = 2'd0,
    OP_MAX = 2'd1,
    OP_LE  = 2'd2,
    OP_LT  = 2'd3
  } mc_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic nan;
    logic snan;
  } fp_cls_t;
endpackage

// File: rtl/fp_class.sv
module fp_class
  import fpu_mc_pkg::*;
#(
  parameter int unsigned E_W = EXP_W,
  parameter int unsigned M_W = MAN_W,
  localparam int unsigned W = 1 + E_W + M_W
) (
  input  logic [W-1:0] val_i,
  output fp_cls_t      cls_o
);
  logic [E_W-1:0] exp_f;
  logic [M_W-1:0] man_f;
  logic           exp_ones;

  assign exp_f    = val_i[W-2 -: E_W];
  assign man_f    = val_i[M_W-1:0];
  assign exp_ones = &exp_f;

  always_comb begin
    cls_o.sign = val_i[W-1];
    cls_o.zero = (exp_f == '0) && (man_f == '0);
    cls_o.inf  = exp_ones && (man_f == '0);
    cls_o.nan  = exp_ones && (man_f != '0);
    cls_o.snan = exp_ones && (man_f != '0) && !man_f[M_W-1];
  end

  always_comb begin
    snan_is_nan_chk: assert (!cls_o.snan || cls_o.nan);
  end
endmodule

// File: rtl/fp_order.sv
module fp_order
  import fpu_mc_pkg::*;
#(
  parameter int unsigned W = FLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fp_cls_t      cls_a_i,
  input  fp_cls_t      cls_b_i,
  output logic         lt_tot_o,  // total order, -0 < +0
  output logic         lt_num_o,  // numeric, zeros equal
  output logic         eq_num_o
);
  logic [W-2:0] mag_a, mag_b;
  logic         both_zero;

  assign mag_a     = a_i[W-2:0];
  assign mag_b     = b_i[W-2:0];
  assign both_zero = cls_a_i.zero && cls_b_i.zero;

  always_comb begin
    if (cls_a_i.sign != cls_b_i.sign) lt_tot_o = cls_a_i.sign;
    else if (cls_a_i.sign)            lt_tot_o = mag_a > mag_b;
    else                              lt_tot_o = mag_a < mag_b;
  end

  assign lt_num_o = lt_tot_o && !both_zero;
  assign eq_num_o = (a_i == b_i) || both_zero;

  always_comb begin
    // R2
    tot_irreflexive_chk: assert (!(lt_tot_o && (a_i == b_i)));
    // R5
    lt_eq_excl_chk: assert (!(lt_num_o && eq_num_o));
  end
endmodule

// File: rtl/fp_mm_pick.sv
module fp_mm_pick
  import fpu_mc_pkg::*;
#(
  parameter int unsigned E_W = EXP_W,
  parameter int unsigned M_W = MAN_W,
  localparam int unsigned W = 1 + E_W + M_W,
  localparam logic [W-1:0] CANON = {1'b0, {E_W{1'b1}}, 1'b1, {(M_W-1){1'b0}}}
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fp_cls_t      cls_a_i,
  input  fp_cls_t      cls_b_i,
  input  logic         lt_tot_i,
  input  logic         is_max_i,
  input  logic         nanprop_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o
);
  logic take_a;

  assign take_a    = is_max_i ? !lt_tot_i : lt_tot_i;
  assign invalid_o = cls_a_i.snan || cls_b_i.snan;

  always_comb begin
    if (cls_a_i.nan || cls_b_i.nan) begin
      if (nanprop_i || (cls_a_i.nan && cls_b_i.nan)) res_o = CANON;
      else if (cls_a_i.nan)                          res_o = b_i;
      else                                           res_o = a_i;
    end else begin
      res_o = take_a ? a_i : b_i;
    end
  end

  always_comb begin
    // R3
    if (cls_a_i.nan && !cls_b_i.nan && !nanprop_i)
      one_nan_pass_chk: assert (res_o == b_i);
    // R9
    if (!cls_a_i.nan && !cls_b_i.nan)
      mm_no_nv_chk: assert (!invalid_o);
  end
endmodule

// File: rtl/fp_minmax_cmp.sv
module fp_minmax_cmp
  import fpu_mc_pkg::*;
#(
  parameter int unsigned E_W = EXP_W,
  parameter int unsigned M_W = MAN_W,
  localparam int unsigned W = 1 + E_W + M_W,
  localparam logic [W-1:0] CANON = {1'b0, {E_W{1'b1}}, 1'b1, {(M_W-1){1'b0}}}
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [1:0]        op_i,
  input  logic              nanprop_i,
  input  logic              quiet_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o
);
  fp_cls_t    cls [2];
  logic [W-1:0] opnd [2];
  logic lt_tot, lt_num, eq_num;
  logic [W-1:0] mm_res;
  logic mm_nv, any_nan, any_snan, is_cmp, cmp_bit, cmp_nv, nv;
  mc_op_e op;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;
  assign op      = mc_op_e'(op_i);

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fp_class #(.E_W(E_W), .M_W(M_W)) u_cls (.val_i(opnd[i]), .cls_o(cls[i]));
  end

  fp_order #(.W(W)) u_ord (
    .a_i(a_i), .b_i(b_i), .cls_a_i(cls[0]), .cls_b_i(cls[1]),
    .lt_tot_o(lt_tot), .lt_num_o(lt_num), .eq_num_o(eq_num)
  );

  fp_mm_pick #(.E_W(E_W), .M_W(M_W)) u_mm (
    .a_i(a_i), .b_i(b_i), .cls_a_i(cls[0]), .cls_b_i(cls[1]),
    .lt_tot_i(lt_tot), .is_max_i(op == OP_MAX), .nanprop_i(nanprop_i),
    .res_o(mm_res), .invalid_o(mm_nv)
  );

  assign any_nan  = cls[0].nan  || cls[1].nan;
  assign any_snan = cls[0].snan || cls[1].snan;
  assign is_cmp   = (op == OP_LE) || (op == OP_LT);

  always_comb begin
    if (any_nan)          cmp_bit = 1'b0;
    else if (op == OP_LE) cmp_bit = lt_num || eq_num;
    else                  cmp_bit = lt_num;
  end

  assign cmp_nv = quiet_i ? any_snan : any_nan;
  assign nv     = is_cmp ? cmp_nv : mm_nv;

  always_comb begin
    flags_o         = '0;
    flags_o[NV_BIT] = nv;
  end

  assign result_o = is_cmp ? {{(W-1){1'b0}}, cmp_bit} : mm_res;

  always_comb begin
    // R10
    flags_lo_zero_chk: assert (flags_o[NV_BIT-1:0] == '0);
    // R5
    if (is_cmp) cmp_bool_chk: assert (result_o[W-1:1] == '0);
    // R4
    if (!is_cmp && nanprop_i && any_nan) nanprop_canon_chk: assert (result_o == CANON);
    // R8
    if (is_cmp && quiet_i && !any_snan) quiet_qnan_chk: assert (!flags_o[NV_BIT]);
    // R6
    if (is_cmp && any_nan) cmp_nan_false_chk: assert (result_o == '0);
  end
endmodule

// File: tb/sim_fp_minmax_cmp.sv
module sim_fp_minmax_cmp;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [1:0]  op;
  logic        np, qt;
  logic [4:0]  flg;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam int NV = 17;
  logic [31:0] vals [NV];
  int key_t [NV];   // total order rank, -1 = NaN
  bit is_sn [NV];

  always #4 clk = ~clk;

  fp_minmax_cmp u0 (
    .a_i(a), .b_i(b), .op_i(op), .nanprop_i(np), .quiet_i(qt),
    .result_o(res), .flags_o(flg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h op=%0d np=%0b q=%0b act=%h exp=%h",
               req, a, b, op, np, qt, act, exp);
    end
  endtask

  initial begin
    vals[0]=32'hff800000; vals[1]=32'hff7fffff; vals[2]=32'hc0000000;
    vals[3]=32'hbf800000; vals[4]=32'h80000001; vals[5]=32'h80000000;
    vals[6]=32'h00000000; vals[7]=32'h00000001; vals[8]=32'h3f800000;
    vals[9]=32'h3fc00000; vals[10]=32'h40000000; vals[11]=32'h7f7fffff;
    vals[12]=32'h7f800000;
    vals[13]=32'h7fc00000; vals[14]=32'hffc00123;
    vals[15]=32'h7f800001; vals[16]=32'hffa00000;
    for (int i = 0; i < NV; i++) begin
      key_t[i] = (i < 13) ? i : -1;
      is_sn[i] = (i >= 15);
    end
    a = '0; b = '0; op = 2'd0; np = 0; qt = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 idle state: min(+0,+0)
    chk("R1", res, 32'h0);
    chk("R10", {27'd0, flg}, 32'h0);

    for (int ia = 0; ia < NV; ia++)
      for (int ib = 0; ib < NV; ib++)
        for (int o = 0; o < 4; o++)
          for (int v = 0; v < 4; v++) begin
            bit an, bn, anyn, anys, cmpo, irr;
            int ka, kb;
            logic [31:0] er;
            logic en;
            string tr, tf;
            @(posedge clk);
            a = vals[ia]; b = vals[ib]; op = o[1:0]; np = v[0]; qt = v[1];
            @(negedge clk);
            an = key_t[ia] < 0; bn = key_t[ib] < 0;
            anyn = an || bn; anys = is_sn[ia] || is_sn[ib];
            cmpo = o >= 2;
            irr  = cmpo ? np : qt;
            ka = key_t[ia]; kb = key_t[ib];
            if (cmpo) begin
              int ca, cb;
              ca = (ka == 5) ? 6 : ka; cb = (kb == 5) ? 6 : kb;
              if (anyn) er = 0;
              else er = {31'd0, (o == 2) ? (ca <= cb) : (ca < cb)};
              en = qt ? anys : anyn;
              tr = anyn ? "R6" : "R5";
              tf = qt ? "R8" : "R7";
            end else begin
              if (anyn) begin
                if (np || (an && bn)) er = 32'h7fc00000;
                else er = an ? vals[ib] : vals[ia];
              end else begin
                bit pick_a;
                pick_a = (o == 0) ? (ka <= kb) : (ka >= kb);
                er = pick_a ? vals[ia] : vals[ib];
              end
              en = anys;
              tr = (anyn && np) ? "R4" : anyn ? "R3" :
                   ((ka == 5 || ka == 6) && (kb == 5 || kb == 6)) ? "R2" : "R1";
              tf = "R9";
            end
            if (irr) begin tr = "R11"; tf = "R11"; end
            chk(tr, res, er);
            chk(tf, {31'd0, flg[4]}, {31'd0, en});
            chk("R10", {28'd0, flg[3:0]}, 32'h0);
          end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule